// File: doc/BRIEF.md
# Bus Write Transaction Coverage Monitor

The monitor sits beside an arbitrated bus and never drives it. Each cycle it compares the request, grant, opcode and memory acknowledge lines against a fixed seven-step write handshake. It keeps the address presented in the third step and the data byte presented in the fourth. Only when all seven steps arrive back to back does it sort the pair into coverage bins. Any step that does not match abandons the attempt and drops whatever had been captured.

A finished write sorts its address into one of five address ranges and its data into one of four data ranges. The pair of ranges then selects one slot of a twenty-entry cross matrix. Every range and slot owns a saturating counter, and a separate counter records how many writes were recognized. A small combinational read port lets a bench or a debug path read any counter by bank and index. A synchronous clear empties all counters at once.

Top module: `bus_wr_cov_mon`

## Requirements
- R1: A write is recognized when seven consecutive cycles show, in order: bus_req high; bus_gnt high; bus_op equal to WRITE (2'b01); bus_op equal to WRITE; mem_ack high; bus_req low; bus_gnt low. No other signals are examined in each step.
- R2: The address is taken from bus_addr in step 3 and the data from bus_data in step 4. Only those captured values are binned.
- R3: Address ranges, in priority order, are index 0 = 0..0, 1 = 1..1023, 2 = 1024..8191, 3 = 8192..32767 and 4 = 32768..65279. The lowest-numbered matching range wins. An address of 65280 or above changes no address counter.
- R4: Data ranges are index 0 = 0..15, 1 = 16..31, 2 = 32..127 and 3 = 128..255. The lowest-numbered matching range wins.
- R5: The cross counter at index address_range*4 + data_range is incremented only when both the address and the data fell in a range.
- R6: A cycle that breaks the sequence returns the recognizer to idle and discards the captured values. If bus_req is high in that cycle, the cycle counts as step 1 of a new attempt.
- R7: All counters, including txn_count, change at the clock edge after the edge that samples step 7, and only for a completed sequence.
- R8: Every counter is CNT_W bits wide and holds at its all-ones value instead of wrapping.
- R9: A high clr at a clock edge zeroes every counter, and takes priority over an increment at that same edge.
- R10: rd_count combinationally returns the selected counter: rd_sel 0 = address bank, 1 = data bank, 2 = cross bank. rd_sel 3, or an index past the end of the bank, returns 0.
- R11: After reset every counter reads 0 and the recognizer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| bus_req | input | 1 | Bus request line |
| bus_gnt | input | 1 | Bus grant line |
| bus_op | input | 2 | Bus opcode (WRITE = 2'b01) |
| bus_addr | input | ADDR_W (16) | Address bus |
| bus_data | input | DATA_W (8) | Data bus |
| mem_ack | input | 1 | Memory acknowledge |
| rd_sel | input | 2 | Counter bank select |
| rd_idx | input | 5 | Counter index within the bank |
| rd_count | output | CNT_W (16) | Selected counter value |
| txn_count | output | CNT_W (16) | Number of recognized writes (saturating) |

## Verification
The properties assume that bus transactions never overlap. In particular, bus_req is low in the step-7 cycle, so a completion never coincides with the start of a new attempt. They also assume clr is a clean synchronous level. The stimulus drives every bus line at the falling edge, returns the bus to idle after each write, and starts a new attempt only from idle or from a deliberate break cycle. In the break tests, bus_req is held high or low on purpose to exercise both outcomes of a sequence failure.

// File: rtl/wcov_pkg.sv
package wcov_pkg;
    localparam logic [1:0] OP_WRITE = 2'b01;

    localparam int NUM_ABIN = 5;
    localparam int NUM_DBIN = 4;
    localparam int NUM_XBIN = NUM_ABIN * NUM_DBIN;

    localparam int unsigned ABIN_LO [NUM_ABIN] = '{0, 1, 1024, 8192, 32768};
    localparam int unsigned ABIN_HI [NUM_ABIN] = '{0, 1023, 8191, 32767, 65279};
    localparam int unsigned DBIN_LO [NUM_DBIN] = '{0, 16, 32, 128};
    localparam int unsigned DBIN_HI [NUM_DBIN] = '{15, 31, 127, 255};

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_CROSS = 2'd2;

    // Recognizer state: number of handshake steps already matched
    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_GNT, ST_ADR, ST_DAT, ST_ACK, ST_REL
    } seq_st_e;
endpackage

// File: rtl/wcov_seq.sv
module wcov_seq
    import wcov_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_gnt,
    input  logic [1:0]        bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              mem_ack,
    output logic              done_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic brk;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        brk        = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: if (bus_req) seq_d.st = ST_REQ;
            ST_REQ:  if (bus_gnt) seq_d.st = ST_GNT; else brk = 1'b1;
            ST_GNT:  if (bus_op == OP_WRITE) begin
                         seq_d.st   = ST_ADR;
                         seq_d.addr = bus_addr;        // R2 address in step 3
                     end else brk = 1'b1;
            ST_ADR:  if (bus_op == OP_WRITE) begin
                         seq_d.st   = ST_DAT;
                         seq_d.data = bus_data;        // R2 data in step 4
                     end else brk = 1'b1;
            ST_DAT:  if (mem_ack)  seq_d.st = ST_ACK; else brk = 1'b1;
            ST_ACK:  if (!bus_req) seq_d.st = ST_REL; else brk = 1'b1;
            ST_REL:  if (!bus_gnt) begin
                         seq_d.st   = ST_IDLE;
                         seq_d.done = 1'b1;            // R1 complete
                     end else brk = 1'b1;
            default: brk = 1'b1;
        endcase
        if (brk) begin
            // R6: drop captured values, reconsider this cycle as step 1
            seq_d.st   = bus_req ? ST_REQ : ST_IDLE;
            seq_d.addr = '0;
            seq_d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, addr: '0, data: '0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign done_o = seq_q.done;
    assign addr_o = seq_q.addr;
    assign data_o = seq_q.data;

    p_done_after_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(!bus_gnt) && $past(!bus_req, 2) && $past(mem_ack, 3)));

    p_break_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_GNT && bus_op != OP_WRITE && bus_req) |=> (seq_q.st == ST_REQ));

    p_break_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DAT && !mem_ack && !bus_req) |=> (seq_q.st == ST_IDLE && addr_o == '0));
endmodule

// File: rtl/wcov_binner.sv
module wcov_binner #(
    parameter int VAL_W = 8,
    parameter int NBIN  = 4,
    parameter int IDX_W = (NBIN > 1) ? $clog2(NBIN) : 1,
    parameter int unsigned LO [NBIN] = '{default: 0},
    parameter int unsigned HI [NBIN] = '{default: 0}
) (
    input  logic [VAL_W-1:0] val,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest-numbered matching range wins (R3, R4)
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NBIN - 1; i >= 0; i--) begin
            if (32'(val) >= LO[i] && 32'(val) <= HI[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wcov_ctr_bank.sv
module wcov_ctr_bank #(
    parameter int NCNT  = 4,
    parameter int CNT_W = 16,
    parameter int IDX_W = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        inc,
    input  logic [IDX_W-1:0]            inc_idx,
    output logic [NCNT-1:0][CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NCNT-1:0][CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;                                 // R9 clear wins
        end else if (inc) begin
            for (int i = 0; i < NCNT; i++) begin
                if (int'(inc_idx) == i && cnt_q[i] != CNT_MAX)
                    cnt_d[i] = cnt_q[i] + 1'b1;         // R8 hold at max
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    for (genvar g = 0; g < NCNT; g++) begin : g_chk
        p_hold_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == CNT_MAX && !clr) |=> (cnt_q[g] == CNT_MAX));
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt_q[g] == '0));
        p_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (cnt_q[g] == $past(cnt_q[g]) ||
                      cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1)));
    end
endmodule

// File: rtl/bus_wr_cov_mon.sv
module bus_wr_cov_mon
    import wcov_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bus_req,
    input  logic              bus_gnt,
    input  logic [1:0]        bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              mem_ack,
    input  logic [1:0]        rd_sel,
    input  logic [4:0]        rd_idx,
    output logic [CNT_W-1:0]  rd_count,
    output logic [CNT_W-1:0]  txn_count
);
    localparam int AIDX_W = $clog2(NUM_ABIN);
    localparam int DIDX_W = $clog2(NUM_DBIN);
    localparam int XIDX_W = $clog2(NUM_XBIN);

    logic              seq_done;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic              a_hit, d_hit;
    logic [AIDX_W-1:0] a_idx;
    logic [DIDX_W-1:0] d_idx;
    logic [XIDX_W-1:0] x_idx;

    logic [NUM_ABIN-1:0][CNT_W-1:0] a_cnt;
    logic [NUM_DBIN-1:0][CNT_W-1:0] d_cnt;
    logic [NUM_XBIN-1:0][CNT_W-1:0] x_cnt;
    logic [0:0][CNT_W-1:0]          t_cnt;

    wcov_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data),
        .mem_ack(mem_ack), .done_o(seq_done), .addr_o(cap_addr), .data_o(cap_data)
    );

    wcov_binner #(.VAL_W(ADDR_W), .NBIN(NUM_ABIN), .IDX_W(AIDX_W),
                  .LO(ABIN_LO), .HI(ABIN_HI)) u_abin (
        .val(cap_addr), .hit(a_hit), .idx(a_idx)
    );

    wcov_binner #(.VAL_W(DATA_W), .NBIN(NUM_DBIN), .IDX_W(DIDX_W),
                  .LO(DBIN_LO), .HI(DBIN_HI)) u_dbin (
        .val(cap_data), .hit(d_hit), .idx(d_idx)
    );

    // R5 cross slot = address range * data range count + data range
    always_comb begin
        x_idx = XIDX_W'(a_idx) * XIDX_W'(NUM_DBIN) + XIDX_W'(d_idx);
    end

    wcov_ctr_bank #(.NCNT(NUM_ABIN), .CNT_W(CNT_W), .IDX_W(AIDX_W)) u_acnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(seq_done && a_hit),
        .inc_idx(a_idx), .cnt_o(a_cnt)
    );

    wcov_ctr_bank #(.NCNT(NUM_DBIN), .CNT_W(CNT_W), .IDX_W(DIDX_W)) u_dcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(seq_done && d_hit),
        .inc_idx(d_idx), .cnt_o(d_cnt)
    );

    wcov_ctr_bank #(.NCNT(NUM_XBIN), .CNT_W(CNT_W), .IDX_W(XIDX_W)) u_xcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(seq_done && a_hit && d_hit),
        .inc_idx(x_idx), .cnt_o(x_cnt)
    );

    wcov_ctr_bank #(.NCNT(1), .CNT_W(CNT_W), .IDX_W(1)) u_tcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(seq_done),
        .inc_idx(1'b0), .cnt_o(t_cnt)
    );

    assign txn_count = t_cnt[0];

    // R10 read port
    always_comb begin
        rd_count = '0;
        unique case (rd_sel)
            SEL_ADDR:
                for (int i = 0; i < NUM_ABIN; i++)
                    if (int'(rd_idx) == i) rd_count = a_cnt[i];
            SEL_DATA:
                for (int i = 0; i < NUM_DBIN; i++)
                    if (int'(rd_idx) == i) rd_count = d_cnt[i];
            SEL_CROSS:
                for (int i = 0; i < NUM_XBIN; i++)
                    if (int'(rd_idx) == i) rd_count = x_cnt[i];
            default: rd_count = '0;
        endcase
    end

    p_cross_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(seq_done && a_hit && d_hit) && !clr) |=> $stable(x_cnt));

    p_txn_only_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_done && !clr) |=> $stable(txn_count));

    p_addr_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && cap_addr > ADDR_W'(ABIN_HI[NUM_ABIN-1]) && !clr) |=> $stable(a_cnt));
endmodule

// File: tb/bus_wr_cov_mon_test.sv
`timescale 1ns/1ps
module bus_wr_cov_mon_test;
    localparam int W    = 4;             // narrow counters so saturation is reachable
    localparam int MAXC = (1 << W) - 1;
    localparam int NV   = 10;
    localparam logic [1:0] WR = 2'b01;

    // {addr[15:0], data[7:0], abin[3:0] (15 = none), dbin[3:0]}
    localparam logic [31:0] VEC [NV] = '{
        {16'd0,     8'd0,   4'd0,  4'd0},
        {16'd1,     8'd15,  4'd1,  4'd0},
        {16'd1023,  8'd16,  4'd1,  4'd1},
        {16'd1024,  8'd31,  4'd2,  4'd1},
        {16'd8191,  8'd32,  4'd2,  4'd2},
        {16'd8192,  8'd127, 4'd3,  4'd2},
        {16'd32768, 8'd128, 4'd4,  4'd3},
        {16'd65279, 8'd255, 4'd4,  4'd3},
        {16'd65280, 8'd200, 4'd15, 4'd3},
        {16'd65535, 8'd5,   4'd15, 4'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic bus_req = 1'b0, bus_gnt = 1'b0, mem_ack = 1'b0;
    logic [1:0] bus_op = 2'b00;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_data = '0;
    logic [1:0] rd_sel = 2'b00;
    logic [4:0] rd_idx = '0;
    logic [W-1:0] rd_count, txn_count;

    int n_run = 0, n_fail = 0;
    int ea [5];
    int ed [4];
    int ex [20];
    int et = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_wr_cov_mon #(.ADDR_W(16), .DATA_W(8), .CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data), .mem_ack(mem_ack),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_count(rd_count), .txn_count(txn_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, input logic [4:0] i, output int v);
        rd_sel = s;
        rd_idx = i;
        #0.01;
        v = int'(rd_count);
    endtask

    task automatic step(input logic r, input logic g, input logic [1:0] o,
                        input logic [15:0] a, input logic [7:0] d, input logic k);
        @(negedge clk);
        bus_req = r; bus_gnt = g; bus_op = o; bus_addr = a; bus_data = d; mem_ack = k;
    endtask

    // Seven handshake steps, then the bus goes idle just after the step-7 edge
    task automatic txn_body(input logic [15:0] a, input logic [7:0] d);
        step(1, 0, 2'b00, 16'hFFFF, 8'hAA, 0);
        step(1, 1, 2'b00, 16'hFFFF, 8'hAA, 0);
        step(1, 1, WR,    a,        8'hAA, 0);
        step(1, 1, WR,    16'hFFFF, d,     0);
        step(1, 1, 2'b00, 16'hFFFF, 8'hAA, 1);
        step(0, 1, 2'b00, 16'h0,    8'h0,  0);
        step(0, 0, 2'b00, 16'h0,    8'h0,  0);
        step(0, 0, 2'b00, 16'h0,    8'h0,  0);
    endtask

    task automatic run_txn(input logic [15:0] a, input logic [7:0] d);
        txn_body(a, d);
        @(negedge clk);
    endtask

    task automatic cmp_all(input string tag);
        int v;
        for (int i = 0; i < 5; i++) begin rd(2'd0, 5'(i), v); chk({tag, " addr bank R3"}, v, ea[i]); end
        for (int i = 0; i < 4; i++) begin rd(2'd1, 5'(i), v); chk({tag, " data bank R4"}, v, ed[i]); end
        for (int i = 0; i < 20; i++) begin rd(2'd2, 5'(i), v); chk({tag, " cross bank R5"}, v, ex[i]); end
        chk({tag, " txn_count R1"}, int'(txn_count), et);
    endtask

    task automatic model_clear();
        foreach (ea[i]) ea[i] = 0;
        foreach (ed[i]) ed[i] = 0;
        foreach (ex[i]) ex[i] = 0;
        et = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        cmp_all("reset R11");

        // R1 R2 R3 R4 R5 table of writes
        for (int k = 0; k < NV; k++) begin
            logic [15:0] a;
            logic [7:0] d;
            int ab, db;
            a  = VEC[k][31:16];
            d  = VEC[k][15:8];
            ab = int'(VEC[k][7:4]);
            db = int'(VEC[k][3:0]);
            run_txn(a, d);
            et++;
            if (ab != 15) ea[ab]++;
            ed[db]++;
            if (ab != 15) ex[ab * 4 + db]++;
            cmp_all($sformatf("vector %0d", k));
        end

        // R6 break at step 3 with request low: nothing counted
        step(1, 0, 2'b00, 0, 0, 0);
        step(1, 1, 2'b00, 0, 0, 0);
        step(0, 1, 2'b11, 16'd5, 0, 0);
        step(0, 1, WR, 0, 8'd5, 0);
        step(0, 1, 2'b00, 0, 0, 1);
        step(0, 0, 2'b00, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmp_all("break idle R6");

        // R6 missing acknowledge in step 5 aborts the write
        step(1, 0, 2'b00, 0, 0, 0);
        step(1, 1, 2'b00, 0, 0, 0);
        step(1, 1, WR, 16'd5, 0, 0);
        step(1, 1, WR, 0, 8'd5, 0);
        step(0, 1, 2'b00, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmp_all("no ack R6");

        // R6 break cycle with request high restarts as step 1
        step(1, 0, 2'b00, 0, 0, 0);
        step(1, 1, 2'b00, 0, 0, 0);
        step(1, 1, 2'b10, 0, 0, 0);      // break, req high -> step 1
        step(1, 1, 2'b00, 0, 0, 0);      // step 2
        step(1, 1, WR, 16'd9000, 0, 0);  // step 3
        step(1, 1, WR, 0, 8'd20, 0);     // step 4
        step(1, 1, 2'b00, 0, 0, 1);
        step(0, 1, 2'b00, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0);
        @(negedge clk);
        et++; ea[3]++; ed[1]++; ex[3 * 4 + 1]++;
        cmp_all("restart R6");

        // R7 timing: unchanged just after the step-7 edge, updated one edge later
        txn_body(16'd1, 8'd1);
        chk("R7 txn before update edge", int'(txn_count), et);
        rd(2'd0, 5'd1, v);
        chk("R7 addr bank before update edge", v, ea[1]);
        @(negedge clk);
        et++; ea[1]++; ed[0]++; ex[4]++;
        chk("R7 txn after update edge", int'(txn_count), et);
        rd(2'd0, 5'd1, v);
        chk("R7 addr bank after update edge", v, ea[1]);

        // R9 clear with priority over a same-edge increment
        txn_body(16'd0, 8'd0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        cmp_all("clear R9");

        // R8 saturation at the all-ones value
        for (int k = 0; k < MAXC + 2; k++) run_txn(16'd0, 8'd0);
        chk("R8 txn saturates", int'(txn_count), MAXC);
        rd(2'd0, 5'd0, v); chk("R8 addr bin saturates", v, MAXC);
        rd(2'd1, 5'd0, v); chk("R8 data bin saturates", v, MAXC);
        rd(2'd2, 5'd0, v); chk("R8 cross slot saturates", v, MAXC);
        rd(2'd0, 5'd1, v); chk("R8 neighbour untouched", v, 0);

        // R10 read port out-of-range selections
        rd(2'd3, 5'd0, v);  chk("R10 sel 3", v, 0);
        rd(2'd0, 5'd5, v);  chk("R10 addr idx 5", v, 0);
        rd(2'd1, 5'd4, v);  chk("R10 data idx 4", v, 0);
        rd(2'd2, 5'd20, v); chk("R10 cross idx 20", v, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule